// File: doc/BRIEF.md
# Serial Addressed Control Latch Bank

This block accepts control frames from a host over three slow wires: a serial clock, a data line and a strobe. It keeps a bank of single-bit control latches that steer a speech-path cross-point switch and a few mode controls. Each frame carries a six-bit address with one data bit after it. When the strobe rises, the addressed latch takes the data bit. Address zero wipes the whole bank. An address with no latch behind it is refused and flagged for one cycle.

All three wires are sampled by a much faster system clock. Each wire passes through a two-stage synchronizer. Rising edges of the serial clock and of the strobe are found from the synchronized copies. Beside the raw latch vector, the block decodes two receiver-volume enables and a reduced-loudspeaker-gain enable from fixed channels.

Top module: `serial_latch_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every latch output and every derived enable is 0. Latch bit 0 is never set.
- R2: A frame is the six address bits, most significant first, then the data bit. Each bit is taken on a rising edge of sck_i. Sending 1,0,0,1,1,0,1 and then raising the strobe sets latch 38 (address 0x26).
- R3: A strobe with data bit 0 and an address from 1 to NUM_CH-1 clears that one latch. All other latches keep their values.
- R4: While stb_i stays low, shifting any number of bits leaves latch_o unchanged.
- R5: A strobe with address 0x00 clears all latches, even when the data bit is 1.
- R6: When more than 7 bits are shifted before a strobe, only the last 7 bits form the frame.
- R7: A strobe with an address of NUM_CH (48) or more changes no latch. It raises addr_err_o for exactly one system clock cycle.
- R8: vol_up_o equals latch 0x17 (23). vol_extra_o is 1 only while latches 0x17 and 0x1F (31) are both set.
- R9: spk_gain_low_o equals latch 0x2F (47).
- R10: latch_o changes on the third rising edge of clk after stb_i rises, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low reset; clears every latch |
| sck_i | input | 1 | Serial clock from the host; data taken on its rising edge |
| sdi_i | input | 1 | Serial data from the host, MSB first |
| stb_i | input | 1 | Strobe; its rising edge commits the frame |
| latch_o | output | NUM_CH (48) | Current state of every control latch |
| vol_up_o | output | 1 | First receiver-volume step enable |
| vol_extra_o | output | 1 | Second receiver-volume step enable, gated by the first |
| spk_gain_low_o | output | 1 | Reduced loudspeaker gain enable |
| addr_err_o | output | 1 | One-cycle pulse for a strobe to an unimplemented address |

## Verification
Each wire reaches its edge detector two system cycles after it changes. The latch update and the error pulse are registered on the third clk edge after the strobe pin rises. The derived enables follow the latches in the same cycle. The driver holds each serial level for four system cycles. It waits eight cycles after a strobe rises before the monitor compares the latch vector, the enables and the count of error pulses. A separate latency check samples on the falling edges after the second and third rising edges, so the exact update cycle is pinned down.

// File: rtl/slb_pkg.sv
`timescale 1ns/1ps
package slb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE      = 2'd0,
        OP_WRITE_BIT = 2'd1,
        OP_CLEAR_ALL = 2'd2,
        OP_REJECT    = 2'd3
    } slb_op_e;

    // Decide what a committed frame does with the latch bank.
    function automatic slb_op_e slb_classify(input int unsigned addr,
                                             input int unsigned n_ch);
        if (addr == 0)
            return OP_CLEAR_ALL;
        else if (addr < n_ch)
            return OP_WRITE_BIT;
        else
            return OP_REJECT;
    endfunction

endpackage

// File: rtl/slb_pin_sync.sv
`timescale 1ns/1ps
module slb_pin_sync #(
    parameter int N_PINS  = 1,
    parameter int STAGES  = 2,
    parameter bit EDGE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] sig_o
);

    typedef struct packed {
        logic [N_PINS-1:0][STAGES-1:0] chain;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        for (int i = 0; i < N_PINS; i++) begin
            chain_d.chain[i] = {chain_q.chain[i][STAGES-2:0], pin_i[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    generate
        if (EDGE) begin : g_edge
            logic [N_PINS-1:0] prev_d, prev_q;

            always_comb begin
                for (int i = 0; i < N_PINS; i++) begin
                    prev_d[i] = chain_q.chain[i][STAGES-1];
                    sig_o[i]  = chain_q.chain[i][STAGES-1] & ~prev_q[i];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= prev_d;
            end
        end else begin : g_level
            always_comb begin
                for (int i = 0; i < N_PINS; i++) begin
                    sig_o[i] = chain_q.chain[i][STAGES-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/slb_shift.sv
`timescale 1ns/1ps
module slb_shift #(
    parameter int FRAME_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) begin
            sh_d.sr = {sh_q.sr[FRAME_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame_o = sh_q.sr;

endmodule

// File: rtl/slb_latches.sv
`timescale 1ns/1ps
module slb_latches
    import slb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W:0]   frame,
    output logic [NUM_CH-1:0] bits_o,
    output logic              err_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] bits;
        logic              err;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [ADDR_W-1:0] addr;
    logic              data;
    slb_op_e           op;

    assign addr = frame[ADDR_W:1];
    assign data = frame[0];

    always_comb begin
        op = OP_IDLE;
        if (commit) op = slb_classify(32'(addr), 32'(NUM_CH));
    end

    always_comb begin
        bank_d     = bank_q;
        bank_d.err = 1'b0;
        case (op)
            OP_CLEAR_ALL: bank_d.bits = '0;
            OP_WRITE_BIT: begin
                for (int i = 1; i < NUM_CH; i++) begin
                    if (addr == ADDR_W'(i)) bank_d.bits[i] = data;
                end
            end
            OP_REJECT:    bank_d.err = 1'b1;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bits_o = bank_q.bits;
    assign err_o  = bank_q.err;

endmodule

// File: rtl/serial_latch_bank.sv
`timescale 1ns/1ps
module serial_latch_bank #(
    parameter int ADDR_W       = 6,
    parameter int NUM_CH       = 48,
    parameter int SYNC_STAGES  = 2,
    parameter int VOL_UP_CH    = 23,
    parameter int VOL_EXTRA_CH = 31,
    parameter int SPK_LOW_CH   = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              stb_i,
    output logic [NUM_CH-1:0] latch_o,
    output logic              vol_up_o,
    output logic              vol_extra_o,
    output logic              spk_gain_low_o,
    output logic              addr_err_o
);

    localparam int FRAME_W = ADDR_W + 1;
    localparam int EV_SCK  = 0;
    localparam int EV_STB  = 1;

    logic [1:0]         edge_w;
    logic [0:0]         data_w;
    logic [FRAME_W-1:0] frame_w;
    logic               stb_rise;
    logic [NUM_CH-1:0]  bits_w;

    slb_pin_sync #(.N_PINS(2), .STAGES(SYNC_STAGES), .EDGE(1'b1)) u_edge_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({stb_i, sck_i}),
        .sig_o (edge_w)
    );

    slb_pin_sync #(.N_PINS(1), .STAGES(SYNC_STAGES), .EDGE(1'b0)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (sdi_i),
        .sig_o (data_w)
    );

    assign stb_rise = edge_w[EV_STB];

    slb_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (edge_w[EV_SCK]),
        .bit_in   (data_w[0]),
        .frame_o  (frame_w)
    );

    slb_latches #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (stb_rise),
        .frame  (frame_w),
        .bits_o (bits_w),
        .err_o  (addr_err_o)
    );

    always_comb begin
        latch_o        = bits_w;
        vol_up_o       = bits_w[VOL_UP_CH];
        vol_extra_o    = bits_w[VOL_UP_CH] & bits_w[VOL_EXTRA_CH];
        spk_gain_low_o = bits_w[SPK_LOW_CH];
    end

endmodule

// File: rtl/slb_checker.sv
`timescale 1ns/1ps
module slb_checker #(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [ADDR_W:0]   frame,
    input logic [NUM_CH-1:0] latches,
    input logic              err,
    input logic              vol_up,
    input logic              vol_extra
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_CH);

    logic [ADDR_W-1:0] addr;
    assign addr = frame[ADDR_W:1];

    a_r1_bit0_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        !latches[0]);

    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(latches));

    a_r5_zero_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == '0) |=> (latches == '0));

    a_r7_reject_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ({1'b0, addr} >= LIMIT)) |=> (err && $stable(latches)));

    a_r7_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r8_extra_needs_up: assert property (@(posedge clk) disable iff (!rst_n)
        vol_extra |-> vol_up);

endmodule

bind serial_latch_bank slb_checker #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (stb_rise),
    .frame     (frame_w),
    .latches   (latch_o),
    .err       (addr_err_o),
    .vol_up    (vol_up_o),
    .vol_extra (vol_extra_o)
);

// File: tb/sim_serial_latch_bank.sv
`timescale 1ns/1ps
module sim_serial_latch_bank;

    localparam int NCH = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, stb = 1'b0;
    logic [NCH-1:0] latch;
    logic vol_up, vol_extra, spk_low, addr_err;

    always #5 clk = ~clk;

    serial_latch_bank u0 (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .stb_i(stb),
        .latch_o(latch), .vol_up_o(vol_up), .vol_extra_o(vol_extra),
        .spk_gain_low_o(spk_low), .addr_err_o(addr_err)
    );

    typedef struct {
        logic [NCH-1:0] lat;
        logic           v1, v2, spk;
        int             errs;
        string          tag;
    } exp_t;

    exp_t           sb[$];
    event           sb_ev;
    int             checks = 0, errors = 0;
    int             err_seen = 0, err_exp = 0;
    logic [NCH-1:0] model = '0;
    bit             done = 0;

    always @(posedge clk) if (rst_n && addr_err) err_seen++;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;   wait_cyc(4);
        sck = 1'b1; wait_cyc(4);
        sck = 1'b0;
    endtask

    task automatic shift_frame(input logic [5:0] a, input logic d);
        for (int i = 5; i >= 0; i--) send_bit(a[i]);
        send_bit(d);
    endtask

    task automatic pulse_strobe();
        wait_cyc(2);
        stb = 1'b1; wait_cyc(4);
        stb = 1'b0; wait_cyc(4);
    endtask

    task automatic model_apply(input logic [5:0] a, input logic d);
        if (a == 0)            model = '0;
        else if (int'(a) < NCH) model[a] = d;
        else                   err_exp++;
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.lat  = model;
        e.v1   = model[23];
        e.v2   = model[23] & model[31];
        e.spk  = model[47];
        e.errs = err_exp;
        e.tag  = tag;
        sb.push_back(e);
        -> sb_ev;
    endtask

    task automatic write(input logic [5:0] a, input logic d, input string tag);
        shift_frame(a, d);
        pulse_strobe();
        model_apply(a, d);
        push(tag);
    endtask

    // monitor: compares design outputs against queued expectations
    initial begin
        forever begin
            @(sb_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(latch == e.lat, {e.tag, " latches"}, 64'(latch), 64'(e.lat));
                chk(vol_up == e.v1 && vol_extra == e.v2 && spk_low == e.spk,
                    {e.tag, " enables"}, {61'd0, vol_up, vol_extra, spk_low},
                    {61'd0, e.v1, e.v2, e.spk});
                chk(err_seen == e.errs, {e.tag, " error pulses"}, 64'(err_seen), 64'(e.errs));
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        chk(latch == '0 && !vol_up && !vol_extra && !spk_low && !addr_err,
            "R1 state during reset", 64'(latch), 64'd0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk(latch == '0, "R1 state after release", 64'(latch), 64'd0);

        write(6'h26, 1'b1, "R2 address 0x26 set");
        write(6'h05, 1'b1, "R2 address 0x05 set");
        write(6'h05, 1'b0, "R3 address 0x05 clear");

        shift_frame(6'h10, 1'b1);
        wait_cyc(4);
        chk(latch == model, "R4 no change while strobe low", 64'(latch), 64'(model));
        pulse_strobe();
        model_apply(6'h10, 1'b1);
        push("R4 commit after shifting");

        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        write(6'h09, 1'b1, "R6 last seven bits");

        write(6'h1F, 1'b1, "R8 extra alone");
        write(6'h17, 1'b1, "R8 both set");
        write(6'h17, 1'b0, "R8 up cleared");
        write(6'h2F, 1'b1, "R9 speaker low set");
        write(6'h2F, 1'b0, "R9 speaker low clear");

        write(6'h30, 1'b1, "R7 address 0x30 rejected");
        write(6'h3F, 1'b0, "R7 address 0x3F rejected");

        shift_frame(6'h2A, 1'b1);
        wait_cyc(2);
        stb = 1'b1;
        wait_cyc(2);
        chk(latch[42] == 1'b0, "R10 not before third edge", 64'(latch[42]), 64'd0);
        wait_cyc(1);
        chk(latch[42] == 1'b1, "R10 on third edge", 64'(latch[42]), 64'd1);
        wait_cyc(3);
        stb = 1'b0;
        wait_cyc(4);
        model_apply(6'h2A, 1'b1);
        push("R10 final state");

        write(6'h00, 1'b1, "R5 clear all with data 1");
        write(6'h03, 1'b1, "R3 set before reset");

        rst_n = 1'b0;
        wait_cyc(2);
        chk(latch == '0 && !vol_up && !spk_low, "R1 mid-run reset", 64'(latch), 64'd0);
        rst_n = 1'b1;
        model = '0;
        wait_cyc(4);

        done = 1;
        summary();
        $finish;
    end

endmodule